// File: doc/BRIEF.md
# Latched 64-bit Timestamp Reader

This block exposes a free-running 64-bit time counter through two read-only 32-bit registers. Software reads the low register first. That read returns the lower half of the counter and, in the same cycle, captures the upper half into a holding register. A later read of the high register returns the captured value. Together the two reads form one coherent 64-bit snapshot, and the counter can carry from the low half into the high half between them without corrupting the result.

The counter is internal. It advances by a parameterised step on every clock, so that it approximates nanoseconds. An access is a one-cycle read strobe with a port select and an access size. The response appears on the next cycle as read data, a valid pulse and an unused flag. An access of the wrong size, or any write, does not touch the holding register.

Top module: `ts_latch_reader`

## Requirements
- R1: After reset, `rd_valid`, `rd_unused` and `rd_data` are all zero and the holding register is zero. A high-port read made before any low-port read returns 0.
- R2: A read is a cycle with `rd_en`=1 and `wr_en`=0. A low-port read (`port_sel`=0) of word size (`acc_size`=2'b10) returns bits 31:0 of the counter value at the strobe edge. That value is on `rd_data` one cycle later, with `rd_valid`=1 and `rd_unused`=0.
- R3: The same low-port word read stores bits 63:32 of that counter value into the holding register.
- R4: A high-port (`port_sel`=1) word read returns the holding register one cycle later. It does not return the live upper half of the counter.
- R5: The holding register keeps its value across any number of high-port reads, until the next low-port word read.
- R6: A read of any size other than word (2'b00 byte, 2'b01 half, 2'b11 double) is an unused access. One cycle later `rd_valid`=1, `rd_unused`=1 and `rd_data`=32'hFFFF_FFFF, and the holding register is unchanged.
- R7: A strobe with `wr_en`=1 is a write. It is ignored: no `rd_valid` pulse follows it and the holding register is unchanged.
- R8: The counter starts at 0 after reset and adds `STEP` on every clock, modulo 2^64. Low-port word reads on consecutive cycles return values that differ by `STEP[31:0]`, modulo 2^32.
- R9: `rd_valid` is high for exactly one cycle after each read strobe, and is low in every cycle that follows a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Access strobe, one cycle per access |
| wr_en | input | 1 | Marks the strobed access as a write (ignored) |
| port_sel | input | 1 | 0 = low half register, 1 = high half register |
| acc_size | input | 2 | 00 byte, 01 half, 10 word, 11 double |
| rd_data | output | 32 | Read response data |
| rd_valid | output | 1 | Response valid, one cycle after the strobe |
| rd_unused | output | 1 | Response is from an unused (wrong-size) access |

## Verification
Every response is due exactly one clock after its strobe, because a single register stage holds the data, valid and unused outputs. The bench drives each strobe on a falling edge and records its own counter model at that moment, which is the value the design samples at the next rising edge. It then checks the outputs on the following falling edge. Effects on the holding register show up one cycle after the low-port read that causes them. They are checked through later high-port reads, made after idle cycles so that the live upper half has moved away from the held value. Back-to-back low-port reads check the step size cycle by cycle.

// File: rtl/ts_pkg.sv
package ts_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } acc_size_e;

    typedef enum logic {
        PORT_LOW  = 1'b0,
        PORT_HIGH = 1'b1
    } port_e;

    // One-hot classification of a strobed access (all zero for no access)
    typedef struct packed {
        logic hit_low;
        logic hit_high;
        logic unused;
    } access_t;

endpackage

// File: rtl/ts_step_counter.sv
module ts_step_counter #(
    parameter int               W    = 64,
    parameter logic [W-1:0]     STEP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/ts_access_decode.sv
module ts_access_decode
    import ts_pkg::*;
(
    input  logic      rd_en,
    input  logic      wr_en,
    input  logic      port_sel,
    input  logic [1:0] acc_size,
    output access_t   acc
);
    logic is_read;
    logic is_word;

    always_comb begin
        is_read      = rd_en & ~wr_en;
        is_word      = (acc_size_e'(acc_size) == SZ_WORD);
        acc.hit_low  = is_read & is_word & (port_e'(port_sel) == PORT_LOW);
        acc.hit_high = is_read & is_word & (port_e'(port_sel) == PORT_HIGH);
        acc.unused   = is_read & ~is_word;
    end
endmodule

// File: rtl/ts_latch_reader.sv
module ts_latch_reader
    import ts_pkg::*;
#(
    parameter int                    DATA_W = 32,
    parameter logic [2*DATA_W-1:0]   STEP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              port_sel,
    input  logic [1:0]        acc_size,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_unused
);
    localparam int TIME_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              unused;
    } rsp_state_t;

    logic [TIME_W-1:0] now;
    access_t           acc;
    rsp_state_t        st_d, st_q;

    ts_step_counter #(
        .W    (TIME_W),
        .STEP (STEP)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .count (now)
    );

    ts_access_decode u_decode (
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .port_sel (port_sel),
        .acc_size (acc_size),
        .acc      (acc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = acc.hit_low | acc.hit_high | acc.unused;
        st_d.unused = acc.unused;
        if (acc.hit_low) begin
            st_d.data = now[DATA_W-1:0];
            st_d.hold = now[TIME_W-1:DATA_W];
        end else if (acc.hit_high) begin
            st_d.data = st_q.hold;
        end else if (acc.unused) begin
            st_d.data = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.data;
    assign rd_valid  = st_q.valid;
    assign rd_unused = st_q.unused;
endmodule

// File: rtl/ts_latch_reader_chk.sv
module ts_latch_reader_chk #(
    parameter int                  DATA_W = 32,
    parameter logic [2*DATA_W-1:0] STEP   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic              port_sel,
    input logic [1:0]        acc_size,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_unused
);
    localparam logic [DATA_W-1:0] STEP_LO = STEP[DATA_W-1:0];

    logic rd_req, low_ok, high_ok;
    assign rd_req  = rd_en && !wr_en;
    assign low_ok  = rd_req && !port_sel && acc_size == 2'b10;
    assign high_ok = rd_req &&  port_sel && acc_size == 2'b10;

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid); // R9
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid); // R7
    AST_BAD_SIZE_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_size != 2'b10) |=> (rd_unused && rd_data == '1)); // R6
    AST_UNUSED_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unused |-> rd_valid); // R6
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (high_ok && $past(high_ok)) |=> $stable(rd_data)); // R5
    AST_STEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (low_ok && $past(low_ok)) |=> (rd_data == $past(rd_data) + STEP_LO)); // R8
endmodule

bind ts_latch_reader ts_latch_reader_chk #(.DATA_W(DATA_W), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .port_sel  (port_sel),
    .acc_size  (acc_size),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_unused (rd_unused)
);

// File: tb/ts_latch_reader_tb.sv
module ts_latch_reader_tb_top;
    localparam logic [63:0] STEP = 64'h0000_0000_4000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, port_sel = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic [31:0] rd_data;
    logic        rd_valid, rd_unused;

    int n_checks = 0;
    int n_errors = 0;
    logic [63:0] mdl;
    logic [31:0] exp_hold;

    always #2 clk = ~clk;

    ts_latch_reader #(.DATA_W(32), .STEP(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .port_sel(port_sel), .acc_size(acc_size),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_unused(rd_unused)
    );

    // Counter model from R8
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdl <= '0;
        else        mdl <= mdl + STEP;
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Strobe one access on a falling edge; returns the response one cycle later
    task automatic access(input logic we, input logic sel, input logic [1:0] sz,
                          output logic [63:0] snap);
        rd_en = 1'b1; wr_en = we; port_sel = sel; acc_size = sz;
        snap = mdl;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] s;
        chk(rd_valid == 0 && rd_unused == 0 && rd_data == 0, "R1", {rd_valid, rd_unused, rd_data}, 0);
        access(1'b0, 1'b1, 2'b10, s);
        chk(rd_valid && !rd_unused && rd_data == 0, "R1", rd_data, 0);
    endtask

    task automatic t_low_read();
        logic [63:0] s;
        idle(3);
        access(1'b0, 1'b0, 2'b10, s);
        chk(rd_valid && !rd_unused, "R2", {rd_valid, rd_unused}, 2'b10);
        chk(rd_data == s[31:0], "R2", rd_data, s[31:0]);
        exp_hold = s[63:32];
        @(negedge clk);
        chk(!rd_valid, "R9", rd_valid, 0);
    endtask

    task automatic t_high_after_low();
        logic [63:0] s;
        idle(6);
        access(1'b0, 1'b1, 2'b10, s);
        chk(rd_valid && rd_data == exp_hold, "R3", rd_data, exp_hold);
        chk(s[63:32] != exp_hold, "R4", s[63:32], exp_hold);
    endtask

    task automatic t_high_repeat();
        logic [63:0] s;
        for (int i = 0; i < 3; i++) begin
            idle(2);
            access(1'b0, 1'b1, 2'b10, s);
            chk(rd_data == exp_hold, "R5", rd_data, exp_hold);
        end
    endtask

    task automatic t_bad_size();
        logic [63:0] s;
        logic [1:0] sizes [3] = '{2'b00, 2'b01, 2'b11};
        for (int i = 0; i < 3; i++) begin
            idle(3);
            access(1'b0, 1'b0, sizes[i], s);
            chk(rd_valid && rd_unused && rd_data == 32'hFFFF_FFFF, "R6", {rd_valid, rd_unused, rd_data}, {2'b11, 32'hFFFF_FFFF});
        end
        idle(2);
        access(1'b0, 1'b1, 2'b01, s);
        chk(rd_unused && rd_data == 32'hFFFF_FFFF, "R6", rd_data, 32'hFFFF_FFFF);
        access(1'b0, 1'b1, 2'b10, s);
        chk(!rd_unused && rd_data == exp_hold, "R6", rd_data, exp_hold);
    endtask

    task automatic t_write();
        logic [63:0] s;
        idle(4);
        access(1'b1, 1'b0, 2'b10, s);
        chk(!rd_valid, "R7", rd_valid, 0);
        idle(2);
        access(1'b0, 1'b1, 2'b10, s);
        chk(rd_valid && rd_data == exp_hold, "R7", rd_data, exp_hold);
    endtask

    task automatic t_back_to_back();
        logic [63:0] m1, m2;
        idle(2);
        rd_en = 1'b1; wr_en = 1'b0; port_sel = 1'b0; acc_size = 2'b10;
        m1 = mdl;
        @(negedge clk);
        m2 = mdl;
        chk(rd_data == m1[31:0], "R2", rd_data, m1[31:0]);
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == m1[31:0] + STEP[31:0], "R8", rd_data, m1[31:0] + STEP[31:0]);
        chk(m2 - m1 == STEP, "R8", m2 - m1, STEP);
        exp_hold = m2[63:32];
        @(negedge clk);
        chk(!rd_valid, "R9", rd_valid, 0);
        idle(5);
        access(1'b0, 1'b1, 2'b10, m1);
        chk(rd_data == exp_hold, "R3", rd_data, exp_hold);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_low_read();
                t_high_after_low();
                t_high_repeat();
                t_bad_size();
                t_write();
                t_back_to_back();
            end
            begin
                #(200000 * 4);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule